// File: doc/BRIEF.md
# Gray Scale Staircase Test Pattern Generator

This block draws one line of a gray scale staircase test bar as digital video samples. A programmable divider turns the pixel clock into step ticks. The horizontal sync input holds the divider in a fixed state, so every line's step boundaries fall at the same distance from the end of sync. A start flip-flop is armed during sync and represents a black step. On the first tick after sync it passes a single token into an eight-position one-hot ring. The token then moves one position per tick. Each position selects its own gray level register. The selected level is limited by a programmable white ceiling, and the floor is code 0.

Software loads eight level values, a white limit and the divider count through a write port. The write port updates shadow copies. The working copies take their value from the shadows only at clock edges where sync is sampled high, so a line that is already running never changes partway. After the eighth gray step the ring is empty, and the output stays black until sync ends again.

Top module: `gray_staircase_gen`

## Requirements
- R1: While `hsync` is sampled high, no step tick occurs, and the output after that edge is 0.
- R2: Count clock edges from the last edge at which `hsync` was sampled high, calling the first edge with `hsync` low edge 1. With divider value D, the output shows gray step k after edges 2+D+k(D+1) through 1+D+(k+1)(D+1).
- R3: Each gray step lasts exactly D+1 clock cycles, where D is the 8-bit value written at address 9.
- R4: Gray steps appear one at a time, in the order step 0 through step 7, and at most one ring position is active.
- R5: A black step of D+1 cycles, with output 0, comes before step 0 on every line.
- R6: Gray step k (0..7) outputs the level written at address k.
- R7: The output never exceeds the white limit written at address 8. Gray step k outputs min(level k, white).
- R8: The output is 0 during sync and during the black step. The black floor is code 0.
- R9: After step 7, the output stays 0 until the next time sync ends.
- R10: Writes (with `wr_en` high at a clock edge) go to shadow registers. The working copies load from the shadows only at edges where `hsync` is high. Writes to addresses 10 to 15 have no effect.
- R11: After reset the output is 0. The levels reset to 0, the white limit to 255 and the divider to 15.
- R12: If sync is raised in the middle of a line, the line stops. When sync falls again, the line restarts from the black step with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync/gate, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0-7 levels, 8 white limit, 9 divider |
| wr_data | input | 8 | Register write data |
| pix_out | output | 8 | Digital video sample |

## Verification
The staircase is driven with several patterns. A rising ramp at a moderate step width checks the ordering and the step timing. A descending set around a white limit of 128, with a divider of 0, checks clipping at its exact boundary and the shortest possible steps. A white limit of 0 with every level at full scale shows that the ceiling overrides the levels. Alternating extremes show whether one step leaks into the next. Directed cases then re-raise sync partway through a line, write registers while a line is running, write to unmapped addresses, and use the largest divider value. Together these separate a phase error, a register loaded too early, and an address decoding fault.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int GS_DATA_W  = 8;
  localparam int GS_N_STEPS = 8;

  // Limit a level to the white ceiling. The floor is code 0, which an unsigned value already respects.
  function automatic logic [GS_DATA_W-1:0] gs_clip(input logic [GS_DATA_W-1:0] lvl,
                                                   input logic [GS_DATA_W-1:0] white);
    return (lvl > white) ? white : lvl;
  endfunction

  // Terminal count test of the step divider.
  function automatic logic gs_at_terminal(input logic [GS_DATA_W-1:0] cnt,
                                          input logic [GS_DATA_W-1:0] tc);
    return cnt == tc;
  endfunction
endpackage

// File: rtl/gs_regfile.sv
module gs_regfile #(
  parameter int DATA_W    = 8,
  parameter int N_STEPS   = 8,
  parameter int ADDR_W    = 4,
  parameter int WHITE_RST = 255,
  parameter int DIV_RST   = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_act,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [N_STEPS-1:0][DATA_W-1:0]  lvl_act,
  output logic [DATA_W-1:0]               white_act,
  output logic [DATA_W-1:0]               div_act
);
  localparam int ADDR_WHITE = N_STEPS;
  localparam int ADDR_DIV   = N_STEPS + 1;

  logic [N_STEPS-1:0][DATA_W-1:0] lvl_sh;
  logic [DATA_W-1:0]              white_sh;
  logic [DATA_W-1:0]              div_sh;

  genvar g;
  generate
    for (g = 0; g < N_STEPS; g++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_sh[g]  <= '0;
          lvl_act[g] <= '0;
        end else begin
          if (wr_en && (int'(wr_addr) == g)) lvl_sh[g] <= wr_data;
          if (load_act) lvl_act[g] <= lvl_sh[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      white_sh  <= DATA_W'(WHITE_RST);
      div_sh    <= DATA_W'(DIV_RST);
      white_act <= DATA_W'(WHITE_RST);
      div_act   <= DATA_W'(DIV_RST);
    end else begin
      if (wr_en && (int'(wr_addr) == ADDR_WHITE)) white_sh <= wr_data;
      if (wr_en && (int'(wr_addr) == ADDR_DIV))   div_sh   <= wr_data;
      if (load_act) begin
        white_act <= white_sh;
        div_act   <= div_sh;
      end
    end
  end
endmodule

// File: rtl/gs_step_clock.sv
module gs_step_clock #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [DATA_W-1:0] term_cnt,
  output logic              step_tick
);
  import gs_pkg::*;

  logic [DATA_W-1:0] cnt;
  logic              at_tc;

  assign at_tc     = gs_at_terminal(cnt, term_cnt);
  assign step_tick = !hold && at_tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (hold)      cnt <= '0;
    else if (at_tc)     cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gs_ring_seq.sv
module gs_ring_seq #(
  parameter int N_STEPS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               step_tick,
  output logic               start_q,
  output logic [N_STEPS-1:0] ring
);
  // The start flip-flop is set during sync and stands for the black step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_q <= 1'b0;
    else if (hold)       start_q <= 1'b1;
    else if (step_tick)  start_q <= 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < N_STEPS; g++) begin : g_ring
      logic feed;
      if (g == 0) begin : g_head
        assign feed = start_q;
      end else begin : g_body
        assign feed = ring[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ring[g] <= 1'b0;
        else if (hold)       ring[g] <= 1'b0;
        else if (step_tick)  ring[g] <= feed;
      end
    end
  endgenerate
endmodule

// File: rtl/gs_level_out.sv
module gs_level_out #(
  parameter int DATA_W  = 8,
  parameter int N_STEPS = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           blank,
  input  logic [N_STEPS-1:0]             ring,
  input  logic [N_STEPS-1:0][DATA_W-1:0] lvl_act,
  input  logic [DATA_W-1:0]              white_act,
  output logic [DATA_W-1:0]              pix_out
);
  import gs_pkg::*;

  logic [N_STEPS-1:0][DATA_W-1:0] masked;
  logic [DATA_W-1:0]              sel_lvl;
  logic [DATA_W-1:0]              pix_next;

  genvar g;
  generate
    for (g = 0; g < N_STEPS; g++) begin : g_mask
      assign masked[g] = ring[g] ? lvl_act[g] : '0;
    end
  endgenerate

  always_comb begin
    sel_lvl = '0;
    for (int i = 0; i < N_STEPS; i++) sel_lvl = sel_lvl | masked[i];
  end

  assign pix_next = blank ? '0 : gs_clip(sel_lvl, white_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_next;
  end
endmodule

// File: rtl/gray_staircase_gen.sv
module gray_staircase_gen #(
  parameter int DATA_W    = gs_pkg::GS_DATA_W,
  parameter int N_STEPS   = gs_pkg::GS_N_STEPS,
  parameter int ADDR_W    = 4,
  parameter int WHITE_RST = 255,
  parameter int DIV_RST   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pix_out
);
  logic [N_STEPS-1:0][DATA_W-1:0] lvl_act;
  logic [DATA_W-1:0]              white_act;
  logic [DATA_W-1:0]              div_act;
  logic                           step_tick;
  logic                           start_q;
  logic [N_STEPS-1:0]             ring;
  logic                           ring_idle;
  logic                           blank;

  assign ring_idle = (ring == '0);
  assign blank     = hsync || start_q || ring_idle;

  gs_regfile #(
    .DATA_W(DATA_W), .N_STEPS(N_STEPS), .ADDR_W(ADDR_W),
    .WHITE_RST(WHITE_RST), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .load_act(hsync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lvl_act(lvl_act), .white_act(white_act), .div_act(div_act)
  );

  gs_step_clock #(.DATA_W(DATA_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .hold(hsync),
    .term_cnt(div_act), .step_tick(step_tick)
  );

  gs_ring_seq #(.N_STEPS(N_STEPS)) u_ring (
    .clk(clk), .rst_n(rst_n), .hold(hsync),
    .step_tick(step_tick), .start_q(start_q), .ring(ring)
  );

  gs_level_out #(.DATA_W(DATA_W), .N_STEPS(N_STEPS)) u_out (
    .clk(clk), .rst_n(rst_n), .blank(blank), .ring(ring),
    .lvl_act(lvl_act), .white_act(white_act), .pix_out(pix_out)
  );
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int DATA_W  = 8,
  parameter int N_STEPS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync,
  input logic               step_tick,
  input logic               start_q,
  input logic [N_STEPS-1:0] ring,
  input logic [DATA_W-1:0]  white_act,
  input logic [DATA_W-1:0]  pix_out
);
  p_no_tick_in_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !step_tick);

  p_black_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> pix_out == '0);

  p_start_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (start_q && ring == '0));

  p_single_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_q, ring}));

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !step_tick) |=> ($stable(ring) && $stable(start_q)));

  p_white_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_out <= white_act);

  p_stays_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !start_q && ring == '0) |=> (ring == '0 && pix_out == '0));
endmodule

bind gray_staircase_gen gs_checker #(.DATA_W(DATA_W), .N_STEPS(N_STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .step_tick(step_tick),
  .start_q(start_q), .ring(ring), .white_act(white_act), .pix_out(pix_out)
);

// File: tb/sim_gray_staircase_gen.sv
module sim_gray_staircase_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pix_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gray_staircase_gen u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pix_out(pix_out)
  );

  // Reference model built from the requirements.
  logic [7:0] sh_lvl [8];
  logic [7:0] ac_lvl [8];
  logic [7:0] sh_white, ac_white, sh_div, ac_div;
  int         edges;
  logic [7:0] exp_pix;
  string      exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin sh_lvl[i] <= 8'd0; ac_lvl[i] <= 8'd0; end
      sh_white <= 8'd255; ac_white <= 8'd255;  // R11 reset values
      sh_div   <= 8'd15;  ac_div   <= 8'd15;
      edges    <= 0;
      exp_pix  <= 8'd0;
      exp_tag  <= "R11";
    end else begin
      // R10: shadow write; addresses 10..15 ignored
      if (wr_en && wr_addr < 4'd8) sh_lvl[wr_addr[2:0]] <= wr_data;
      if (wr_en && wr_addr == 4'd8) sh_white <= wr_data;
      if (wr_en && wr_addr == 4'd9) sh_div   <= wr_data;
      if (hsync) begin
        for (int i = 0; i < 8; i++) ac_lvl[i] <= sh_lvl[i];
        ac_white <= sh_white;
        ac_div   <= sh_div;
        edges    <= 0;
        exp_pix  <= 8'd0;
        exp_tag  <= "R1";
      end else begin
        int n, d, k;
        n = edges + 1;
        d = int'(ac_div) + 1;
        if (edges < 100000) edges <= n;
        if (n < 1 + d) begin
          exp_pix <= 8'd0; exp_tag <= "R5";
        end else begin
          k = (n - 1 - d) / d;
          if (k >= 8) begin
            exp_pix <= 8'd0; exp_tag <= "R9";
          end else if (ac_lvl[k] > ac_white) begin
            exp_pix <= ac_white; exp_tag <= "R7";
          end else begin
            exp_pix <= ac_lvl[k]; exp_tag <= "R6";
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (chk_on && !done) begin
      n_chk++;
      if (pix_out !== exp_pix) begin
        n_bad++;
        $display("FAIL %s cycle %0d: pix_out=%0d expected=%0d", exp_tag, cyc, pix_out, exp_pix);
      end
    end
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input int len);
    hsync = 1'b1; wait_cyc(3);
    hsync = 1'b0; wait_cyc(len);
  endtask

  // Vector table: divider, white, levels (step 7 first ... step 0 last)
  typedef struct packed {
    logic [7:0]  dv;
    logic [7:0]  wh;
    logic [63:0] lv;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd3, 8'd255, {8'd220, 8'd190, 8'd160, 8'd130, 8'd100, 8'd70, 8'd40, 8'd10}},
    '{8'd0, 8'd128, {8'd0, 8'd1, 8'd127, 8'd128, 8'd129, 8'd150, 8'd200, 8'd255}},
    '{8'd5, 8'd0,   {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}},
    '{8'd1, 8'd200, {8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0}}
  };

  initial begin
    // R11: output is 0 while in and right after reset
    wait_cyc(3);
    n_chk++;
    if (pix_out !== 8'd0) begin
      n_bad++; $display("FAIL R11 in reset: pix_out=%0d expected=0", pix_out);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R11: a line with reset contents gives all black (levels 0, divider 15)
    run_line(2 + 15 + 9 * 16 + 4);

    // Table walk: R2, R3, R4, R5, R6, R7, R8, R9 timing and levels
    foreach (VECS[v]) begin
      for (int i = 0; i < 8; i++) wr(4'(i), VECS[v].lv[i*8 +: 8]);
      wr(4'd8, VECS[v].wh);
      wr(4'd9, VECS[v].dv);
      run_line(2 + int'(VECS[v].dv) + 9 * (int'(VECS[v].dv) + 1) + 5);
    end

    // R10: write during a running line must not alter it, but applies on the next line
    for (int i = 0; i < 8; i++) wr(4'(i), 8'(20 * i + 5));
    wr(4'd8, 8'd255); wr(4'd9, 8'd2);
    hsync = 1'b1; wait_cyc(2); hsync = 1'b0;
    wait_cyc(6);
    wr(4'd2, 8'd250); wr(4'd9, 8'd7); wr(4'd8, 8'd100);
    wait_cyc(30);
    run_line(2 + 7 + 9 * 8 + 3);

    // R10: writes to unmapped addresses 10..15 have no visible effect
    for (int a = 10; a < 16; a++) wr(4'(a), 8'h00);
    run_line(2 + 7 + 9 * 8 + 3);

    // R12: sync raised mid-line aborts; restart keeps R2 phase
    hsync = 1'b1; wait_cyc(2); hsync = 1'b0;
    wait_cyc(35);
    run_line(2 + 7 + 9 * 8 + 3);

    // R3: largest divider value
    wr(4'd9, 8'd255);
    run_line(2 + 255 + 9 * 256 + 3);

    // R1: long sync keeps output black throughout
    hsync = 1'b1; wait_cyc(40); hsync = 1'b0; wait_cyc(5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule